// File: doc/BRIEF.md
# Single-Operand Byte ALU with Condition Flags

This unit applies one of twelve unary operations to an 8-bit value. The operations are negate, ones' complement, three right shifts, two left shifts or rotates, decrement, increment, test, nibble exchange and clear. The caller supplies a 4-bit operation code, the operand and the present carry (C), overflow (V), negative (N) and zero (Z) flags. One clock later the unit returns the result, the new flags, a write-enable telling the caller whether to store the result, and an invalid flag for the four codes that have no operation in this group.

The unit sits in the execute stage of a small processor. Operand fetch and address generation happen upstream. The unit itself is purely combinational, followed by one register stage on every output.

Top module: `obyte_alu`

## Requirements
- R1: A request taken while `in_valid` is high appears on the outputs with `out_valid` high exactly one clock later. A cycle with `in_valid` low gives `out_valid`, `wr_en` and `bad_op` low one clock later. While `rst` is high, every output is 0.
- R2: Code 0x0 writes the two's-complement negation of the operand. C becomes 1 unless the operand is 0x00. V becomes 1 only for the operand 0x80.
- R3: Code 0x3 writes the bitwise inverse of the operand and sets C to 1. V is kept.
- R4: Code 0x4 shifts right with 0 entering bit 7, and the old bit 0 goes to C. V is kept.
- R5: Code 0x6 rotates right through carry: the old C enters bit 7 and the old bit 0 becomes C. V is kept.
- R6: Code 0x7 shifts right with bit 7 repeated, and the old bit 0 goes to C. V is kept.
- R7: Code 0x8 shifts left with 0 entering bit 0. Code 0x9 shifts left with the old C entering bit 0. For both, the old bit 7 goes to C and V is kept.
- R8: Code 0xA writes the operand minus 1 and code 0xC writes the operand plus 1, both modulo 256. C is kept. V becomes 1 only when decrementing 0x80 or incrementing 0x7F.
- R9: Code 0xD leaves `wr_en` low and presents the operand on `result`. N and Z are set from the operand, and C and V are kept.
- R10: Code 0xE writes the operand with its high and low 4-bit halves exchanged. C and V are kept.
- R11: Code 0xF writes 0x00 with N = 0 and Z = 1. C and V are kept.
- R12: Codes 0x1, 0x2, 0x5 and 0xB raise `bad_op`, keep `wr_en` low, present the operand unchanged on `result`, and return all four flags exactly as supplied.
- R13: For every code other than the four in R12, N equals bit 7 of `result` and Z is 1 exactly when `result` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| operand | input | 8 | Value to operate on |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result present this cycle |
| result | output | 8 | Operation result |
| c_out | output | 1 | Updated carry flag |
| v_out | output | 1 | Updated overflow flag |
| n_out | output | 1 | Updated negative flag |
| z_out | output | 1 | Updated zero flag |
| wr_en | output | 1 | Result is to be stored |
| bad_op | output | 1 | Code not assigned in this group |

## Verification
The properties assume that `op`, `operand` and the four incoming flags are known and steady across each clock edge at which `in_valid` is high. They also assume that `rst` goes high only at a clock edge. The stimulus meets both assumptions by changing every input only on the falling edge. It sweeps all sixteen codes, including the unassigned ones, over sign-boundary, zero, all-ones and mixed-bit operands, with both carry values and with the incoming V, N and Z set against the expected outcome. Idle gaps are inserted so that `out_valid` is seen to drop.

// File: rtl/obyte_pkg.sv
package obyte_pkg;

  typedef enum logic [3:0] {
    UOP_NEG  = 4'h0,
    UOP_RSV1 = 4'h1,
    UOP_RSV2 = 4'h2,
    UOP_CPL  = 4'h3,
    UOP_SRL  = 4'h4,
    UOP_RSV5 = 4'h5,
    UOP_RRC  = 4'h6,
    UOP_SRA  = 4'h7,
    UOP_SLL  = 4'h8,
    UOP_RLC  = 4'h9,
    UOP_DEC  = 4'hA,
    UOP_RSVB = 4'hB,
    UOP_INC  = 4'hC,
    UOP_TNZ  = 4'hD,
    UOP_SWAP = 4'hE,
    UOP_CLR  = 4'hF
  } uop_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

endpackage

// File: rtl/obyte_shift.sv
module obyte_shift
  import obyte_pkg::*;
#(
  parameter int DW = 8
) (
  input  uop_e          op_i,
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          hit_o
);
  localparam int HALF = DW / 2;
  localparam int MSB  = DW - 1;

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    hit_o = 1'b1;
    unique case (op_i)
      UOP_SRL:  begin res_o = {1'b0, a_i[MSB:1]};    c_o = a_i[0];   end
      UOP_RRC:  begin res_o = {c_i, a_i[MSB:1]};     c_o = a_i[0];   end
      UOP_SRA:  begin res_o = {a_i[MSB], a_i[MSB:1]}; c_o = a_i[0];  end
      UOP_SLL:  begin res_o = {a_i[MSB-1:0], 1'b0};  c_o = a_i[MSB]; end
      UOP_RLC:  begin res_o = {a_i[MSB-1:0], c_i};   c_o = a_i[MSB]; end
      UOP_SWAP: begin res_o = {a_i[HALF-1:0], a_i[MSB:HALF]};       end
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/obyte_arith.sv
module obyte_arith
  import obyte_pkg::*;
#(
  parameter int DW = 8
) (
  input  uop_e          op_i,
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  input  logic          v_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o,
  output logic          hit_o
);
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    v_o   = v_i;
    hit_o = 1'b1;
    unique case (op_i)
      UOP_NEG: begin
        res_o = ~a_i + ONE;
        c_o   = |a_i;
        v_o   = (a_i == MIN_NEG);
      end
      UOP_CPL: begin
        res_o = ~a_i;
        c_o   = 1'b1;
      end
      UOP_DEC: begin
        res_o = a_i - ONE;
        v_o   = (a_i == MIN_NEG);
      end
      UOP_INC: begin
        res_o = a_i + ONE;
        v_o   = (a_i == MAX_POS);
      end
      UOP_CLR: res_o = '0;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/obyte_alu.sv
module obyte_alu
  import obyte_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] operand,
  input  logic          c_in,
  input  logic          v_in,
  input  logic          n_in,
  input  logic          z_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          c_out,
  output logic          v_out,
  output logic          n_out,
  output logic          z_out,
  output logic          wr_en,
  output logic          bad_op
);
  localparam int MSB = DW - 1;

  uop_e          uop;
  logic [DW-1:0] sh_res, ar_res, nxt_res;
  logic          sh_c, sh_hit, ar_c, ar_v, ar_hit;
  logic          nxt_wr, nxt_bad;
  flags_t        fl_in, nxt_fl;

  assign uop   = uop_e'(op);
  assign fl_in = '{c: c_in, v: v_in, n: n_in, z: z_in};

  obyte_shift #(.DW(DW)) shift_u (
    .op_i (uop),
    .a_i  (operand),
    .c_i  (c_in),
    .res_o(sh_res),
    .c_o  (sh_c),
    .hit_o(sh_hit)
  );

  obyte_arith #(.DW(DW)) arith_u (
    .op_i (uop),
    .a_i  (operand),
    .c_i  (c_in),
    .v_i  (v_in),
    .res_o(ar_res),
    .c_o  (ar_c),
    .v_o  (ar_v),
    .hit_o(ar_hit)
  );

  always_comb begin
    nxt_res = operand;
    nxt_fl  = fl_in;
    nxt_wr  = 1'b0;
    nxt_bad = 1'b0;
    if (sh_hit) begin
      nxt_res  = sh_res;
      nxt_fl.c = sh_c;
      nxt_wr   = 1'b1;
    end else if (ar_hit) begin
      nxt_res  = ar_res;
      nxt_fl.c = ar_c;
      nxt_fl.v = ar_v;
      nxt_wr   = 1'b1;
    end else if (uop != UOP_TNZ) begin
      nxt_bad = 1'b1;
    end
    if (!nxt_bad) begin
      nxt_fl.n = nxt_res[MSB];
      nxt_fl.z = (nxt_res == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      c_out     <= 1'b0;
      v_out     <= 1'b0;
      n_out     <= 1'b0;
      z_out     <= 1'b0;
      wr_en     <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & nxt_wr;
      bad_op    <= in_valid & nxt_bad;
      if (in_valid) begin
        result <= nxt_res;
        c_out  <= nxt_fl.c;
        v_out  <= nxt_fl.v;
        n_out  <= nxt_fl.n;
        z_out  <= nxt_fl.z;
      end
    end
  end
endmodule

// File: rtl/obyte_alu_chk.sv
module obyte_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] operand,
  input logic          c_in,
  input logic          v_in,
  input logic          n_in,
  input logic          z_in,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          c_out,
  input logic          v_out,
  input logic          n_out,
  input logic          z_out,
  input logic          wr_en,
  input logic          bad_op
);
  logic unassigned;
  assign unassigned = (op == 4'h1) || (op == 4'h2) || (op == 4'h5) || (op == 4'hB);

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !wr_en && !bad_op);

  assert_carry_kept_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 4'hA || op == 4'hC) |=> c_out == $past(c_in));

  assert_no_store_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'hD |=> !wr_en && result == $past(operand));

  assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 4'hF |=> result == '0 && z_out && !n_out);

  assert_unassigned_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid && unassigned |=> bad_op && !wr_en && result == $past(operand)
      && {c_out, v_out, n_out, z_out} == $past({c_in, v_in, n_in, z_in}));

  assert_nz_follow_R13: assert property (@(posedge clk) disable iff (rst)
    out_valid && !bad_op |-> n_out == result[DW-1] && z_out == (result == '0));

  assert_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && bad_op));
endmodule

bind obyte_alu obyte_alu_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
  .c_in(c_in), .v_in(v_in), .n_in(n_in), .z_in(z_in),
  .out_valid(out_valid), .result(result), .c_out(c_out), .v_out(v_out),
  .n_out(n_out), .z_out(z_out), .wr_en(wr_en), .bad_op(bad_op)
);

// File: tb/obyte_alu_tb.sv
`timescale 1ns/1ps
module obyte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [3:0] op;
  logic [7:0] operand;
  logic       c_in, v_in, n_in, z_in;
  logic       out_valid;
  logic [7:0] result;
  logic       c_out, v_out, n_out, z_out, wr_en, bad_op;

  int vectors = 0;
  int miss = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] res;
    logic c, v, n, z, wr, bad;
    logic [3:0] op;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  obyte_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .c_in(c_in), .v_in(v_in), .n_in(n_in), .z_in(z_in),
    .out_valid(out_valid), .result(result), .c_out(c_out), .v_out(v_out),
    .n_out(n_out), .z_out(z_out), .wr_en(wr_en), .bad_op(bad_op)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h0: return "R2";
      4'h3: return "R3";
      4'h4: return "R4";
      4'h6: return "R5";
      4'h7: return "R6";
      4'h8, 4'h9: return "R7";
      4'hA, 4'hC: return "R8";
      4'hD: return "R9";
      4'hE: return "R10";
      4'hF: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [7:0] a,
                                 input logic c, v, n, z);
    exp_t e;
    int   s;
    e.op = o; e.res = a; e.c = c; e.v = v; e.n = n; e.z = z;
    e.wr = 1'b1; e.bad = 1'b0;
    case (o)
      4'h0: begin s = 256 - a; e.res = s[7:0]; e.c = (a != 0); e.v = (a == 8'd128); end
      4'h3: begin e.res = 8'hFF ^ a; e.c = 1'b1; end
      4'h4: begin e.res = a / 2; e.c = a[0]; end
      4'h6: begin e.res = (a / 2) + (c ? 8'd128 : 8'd0); e.c = a[0]; end
      4'h7: begin e.res = (a / 2) + (a >= 8'd128 ? 8'd128 : 8'd0); e.c = a[0]; end
      4'h8: begin s = a * 2; e.res = s[7:0]; e.c = s[8]; end
      4'h9: begin s = a * 2 + c; e.res = s[7:0]; e.c = s[8]; end
      4'hA: begin s = a + 255; e.res = s[7:0]; e.v = (a == 8'd128); end
      4'hC: begin s = a + 1; e.res = s[7:0]; e.v = (a == 8'd127); end
      4'hD: e.wr = 1'b0;
      4'hE: e.res = (a * 16) | (a / 16);
      4'hF: e.res = 8'd0;
      default: begin e.wr = 1'b0; e.bad = 1'b1; end
    endcase
    if (!e.bad) begin
      e.n = (e.res >= 8'd128);  // R13
      e.z = (e.res == 8'd0);
    end
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic c, v, n, z);
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = a;
    c_in = c; v_in = v; n_in = n; z_in = z;
    sb.push_back(model(o, a, c, v, n, z));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      exp_t e;
      vectors++;
      if (sb.size() == 0) begin
        miss++;
        $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        if ({result, c_out, v_out, n_out, z_out, wr_en, bad_op} !==
            {e.res, e.c, e.v, e.n, e.z, e.wr, e.bad}) begin
          miss++;
          $display("FAIL %s op=%h: actual res=%h cvnz=%b%b%b%b wr=%b bad=%b expected res=%h cvnz=%b%b%b%b wr=%b bad=%b",
                   req_of(e.op), e.op, result, c_out, v_out, n_out, z_out, wr_en, bad_op,
                   e.res, e.c, e.v, e.n, e.z, e.wr, e.bad);
        end
      end
    end
  end

  initial begin
    #200000;
    miss++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    logic [7:0] vals [8];
    vals = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5, 8'h5A, 8'h81};
    rst = 1'b1; in_valid = 1'b0; op = 4'h0; operand = 8'h00;
    c_in = 1'b0; v_in = 1'b0; n_in = 1'b0; z_in = 1'b0;
    repeat (4) @(negedge clk);
    vectors++;  // R1 reset state
    if ({out_valid, result, c_out, v_out, n_out, z_out, wr_en, bad_op} !== '0) begin
      miss++;
      $display("FAIL R1: reset outputs actual %b expected 0",
               {out_valid, result, c_out, v_out, n_out, z_out, wr_en, bad_op});
    end
    rst = 1'b0;
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 8; k++) begin
        for (int c = 0; c < 2; c++) begin
          // flip incoming V, N, Z against the operand to expose kept/updated flags
          drive(o[3:0], vals[k], c[0], ~c[0] ^ k[0], vals[k] < 8'd128, vals[k] != 0);
        end
      end
      idle();
    end
    // R1: idle gap seen at ports
    idle();
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || bad_op !== 1'b0) begin
      miss++;
      $display("FAIL R1: idle outputs actual %b%b%b expected 000", out_valid, wr_en, bad_op);
    end
    vectors++;
    if (sb.size() != 0) begin
      miss++;
      $display("FAIL R1: results missing, actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule